// File: doc/BRIEF.md
# Dual-Direction Bus Register

This block carries an 18-bit word between two ports, A and B, in both directions. The two directions are separate lanes with the same design. Each lane is steered by four controls of its own:

- an active-low drive enable;
- a pass control that makes the lane transparent;
- a strobe whose rising edge captures the input word;
- a freeze control that blocks captures while it is high.

With these controls a lane can isolate its output, pass data straight through, hold a word, capture a word on a strobe edge, or ignore strobe edges.

The pass, strobe and freeze controls come from outside and are asynchronous to the block. Each lane samples them through a short synchronizer chain on the system clock. A strobe rising edge is a synchronized low followed by a synchronized high. The lane's output data and its drive enable are separate signals. A pad ring or tri-state wrapper can combine them outside the block. No handshake exists at either edge, so nothing can be held back. Data stays valid as long as the lane is transparent or holds a stored word.

Top module: `dual_bus_register`

## Requirements
- R1: The data width is a parameter with a default of 18 bits. A full-width word passes from input to output with every bit intact, including the most significant bit.
- R2: `b_drive` is always the inverse of `ab_oe_n`, and `a_drive` is always the inverse of `ba_oe_n`. This holds in the same cycle and whatever the other controls are. While a drive enable is low, the lane's output is isolated.
- R3: While a lane's synchronized pass control is high, its output equals its input word in the same cycle. Strobe and freeze activity has no effect during this time.
- R4: With pass and freeze both low, a strobe that was low and is first sampled high at system clock edge k is captured. The lane stores the input word present at edge k+2, and the output shows it after edge k+2.
- R5: With pass low, a strobe that stays high or stays low, or that falls, leaves the output unchanged even when the input word changes.
- R6: While freeze is high and pass is low, strobe rising edges are ignored and the output keeps its prior value.
- R7: While the lane is transparent, the storage tracks the input on every cycle. After pass falls, the output holds the input word from the last cycle in which the synchronized pass was still high.
- R8: A synchronous reset (`rst` high) clears both stored words and the synchronizers. In the first cycle after reset is released, both outputs are zero. They stay zero until a pass or a strobe edge loads new data.
- R9: The A-to-B and B-to-A lanes are independent. Activity on one lane's controls or input never changes the other lane's output.
- R10: A change on a pass control takes effect after two system clock edges. If pass rises before edge k, the output still shows stored data after edge k and follows the input after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 18 | Word arriving on port A, feeding the A-to-B lane |
| a_out | output | 18 | Word the B-to-A lane presents to port A |
| a_drive | output | 1 | High when port A should be driven with a_out |
| b_in | input | 18 | Word arriving on port B, feeding the B-to-A lane |
| b_out | output | 18 | Word the A-to-B lane presents to port B |
| b_drive | output | 1 | High when port B should be driven with b_out |
| ab_oe_n | input | 1 | A-to-B drive enable, active low |
| ab_pass | input | 1 | A-to-B transparent control, active high |
| ab_strobe | input | 1 | A-to-B capture strobe, rising edge active |
| ab_hold | input | 1 | A-to-B freeze, high blocks strobe captures |
| ba_oe_n | input | 1 | B-to-A drive enable, active low |
| ba_pass | input | 1 | B-to-A transparent control, active high |
| ba_strobe | input | 1 | B-to-A capture strobe, rising edge active |
| ba_hold | input | 1 | B-to-A freeze, high blocks strobe captures |

## Verification
The lanes are driven through these sequences:
- transparent passing of full-width words while the strobe toggles;
- a pass fall followed by an input change;
- a single strobe rise, followed by a steady-high strobe and then a falling strobe;
- strobe rises while frozen;
- reset in the middle of operation.

Sampling the output one cycle before and one cycle after the expected update tells the exact latency apart from an off-by-one pipeline. A changing input under a steady strobe separates edge capture from level capture. Driving one lane while watching the other separates the two lanes' state and controls.

// File: rtl/dbr_pkg.sv
package dbr_pkg;
  localparam int unsigned DBR_WIDTH = 18;
  localparam int unsigned DBR_SYNC  = 2;
  localparam int unsigned DBR_DIRS  = 2;

  // lane index used to map ports onto the generated lanes
  localparam int unsigned DIR_AB = 0;
  localparam int unsigned DIR_BA = 1;

  typedef struct packed {
    logic pass;
    logic strobe;
    logic hold;
  } dbr_ctrl_t;
endpackage

// File: rtl/dbr_ctrl_sync.sv
module dbr_ctrl_sync
  import dbr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = DBR_SYNC
) (
  input  logic      clk,
  input  logic      rst,
  input  dbr_ctrl_t raw,
  output dbr_ctrl_t synced,
  output logic      strobe_rise
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  dbr_ctrl_t stage [SYNC_STAGES];
  logic      strobe_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SYNC_STAGES; i++) stage[i] <= '0;
      strobe_prev <= 1'b0;
    end else begin
      stage[0] <= raw;
      for (int i = 1; i < SYNC_STAGES; i++) stage[i] <= stage[i-1];
      strobe_prev <= stage[LAST].strobe;
    end
  end

  assign synced      = stage[LAST];
  assign strobe_rise = stage[LAST].strobe & ~strobe_prev;
endmodule

// File: rtl/dbr_lane.sv
module dbr_lane
  import dbr_pkg::*;
#(
  parameter int unsigned WIDTH = DBR_WIDTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  input  dbr_ctrl_t        ctrl,
  input  logic             strobe_rise,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] store_q;
  logic             capture;

  // edge capture only when not transparent and not frozen
  assign capture = strobe_rise & ~ctrl.pass & ~ctrl.hold;

  always_ff @(posedge clk) begin
    if (rst)            store_q <= '0;
    else if (ctrl.pass) store_q <= din;
    else if (capture)   store_q <= din;
  end

  assign dout = ctrl.pass ? din : store_q;
endmodule

// File: rtl/dual_bus_register.sv
module dual_bus_register
  import dbr_pkg::*;
#(
  parameter int unsigned WIDTH       = DBR_WIDTH,
  parameter int unsigned SYNC_STAGES = DBR_SYNC
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_drive,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_drive,
  input  logic             ab_oe_n,
  input  logic             ab_pass,
  input  logic             ab_strobe,
  input  logic             ab_hold,
  input  logic             ba_oe_n,
  input  logic             ba_pass,
  input  logic             ba_strobe,
  input  logic             ba_hold
);
  logic [WIDTH-1:0] lane_din  [DBR_DIRS];
  logic [WIDTH-1:0] lane_dout [DBR_DIRS];
  dbr_ctrl_t        lane_raw  [DBR_DIRS];
  dbr_ctrl_t        lane_sync [DBR_DIRS];
  logic             lane_rise [DBR_DIRS];

  assign lane_din[DIR_AB] = a_in;
  assign lane_din[DIR_BA] = b_in;
  assign lane_raw[DIR_AB] = '{pass: ab_pass, strobe: ab_strobe, hold: ab_hold};
  assign lane_raw[DIR_BA] = '{pass: ba_pass, strobe: ba_strobe, hold: ba_hold};

  for (genvar d = 0; d < DBR_DIRS; d++) begin : g_lane
    dbr_ctrl_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk         (clk),
      .rst         (rst),
      .raw         (lane_raw[d]),
      .synced      (lane_sync[d]),
      .strobe_rise (lane_rise[d])
    );

    dbr_lane #(.WIDTH(WIDTH)) u_lane (
      .clk         (clk),
      .rst         (rst),
      .din         (lane_din[d]),
      .ctrl        (lane_sync[d]),
      .strobe_rise (lane_rise[d]),
      .dout        (lane_dout[d])
    );
  end

  assign b_out   = lane_dout[DIR_AB];
  assign a_out   = lane_dout[DIR_BA];
  // drive enables stay under direct external control, also in reset
  assign b_drive = ~ab_oe_n;
  assign a_drive = ~ba_oe_n;
endmodule

// File: rtl/dbr_checker.sv
module dbr_checker #(
  parameter int unsigned WIDTH       = 18,
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] a_out,
  input logic             a_drive,
  input logic [WIDTH-1:0] b_in,
  input logic [WIDTH-1:0] b_out,
  input logic             b_drive,
  input logic             ab_oe_n,
  input logic             ab_pass,
  input logic             ab_strobe,
  input logic             ab_hold,
  input logic             ba_oe_n,
  input logic             ba_pass,
  input logic             ba_strobe,
  input logic             ba_hold
);
  localparam logic [7:0] WIN = 8'(SYNC_STAGES);

  logic [7:0] ab_pass_run, ba_pass_run, ab_frz_run, ba_frz_run;

  // consecutive-cycle counters replace deep $past windows
  always_ff @(posedge clk) begin
    if (rst) begin
      ab_pass_run <= '0; ba_pass_run <= '0;
      ab_frz_run  <= '0; ba_frz_run  <= '0;
    end else begin
      ab_pass_run <= ab_pass ? ((ab_pass_run == 8'hFF) ? ab_pass_run : ab_pass_run + 8'd1) : 8'd0;
      ba_pass_run <= ba_pass ? ((ba_pass_run == 8'hFF) ? ba_pass_run : ba_pass_run + 8'd1) : 8'd0;
      ab_frz_run  <= (ab_hold && !ab_pass) ? ((ab_frz_run == 8'hFF) ? ab_frz_run : ab_frz_run + 8'd1) : 8'd0;
      ba_frz_run  <= (ba_hold && !ba_pass) ? ((ba_frz_run == 8'hFF) ? ba_frz_run : ba_frz_run + 8'd1) : 8'd0;
    end
  end

  AST_DRIVE_B_TRACKS_OE: assert property (@(posedge clk) disable iff (rst) b_drive != ab_oe_n); // R2
  AST_DRIVE_A_TRACKS_OE: assert property (@(posedge clk) disable iff (rst) a_drive != ba_oe_n); // R2
  AST_AB_TRANSPARENT: assert property (@(posedge clk) disable iff (rst) (ab_pass_run >= WIN) |-> (b_out == a_in)); // R3
  AST_BA_TRANSPARENT: assert property (@(posedge clk) disable iff (rst) (ba_pass_run >= WIN) |-> (a_out == b_in)); // R3
  AST_AB_FROZEN: assert property (@(posedge clk) disable iff (rst) (ab_frz_run >= WIN) |=> $stable(b_out)); // R6
  AST_BA_FROZEN: assert property (@(posedge clk) disable iff (rst) (ba_frz_run >= WIN) |=> $stable(a_out)); // R6
  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst) $fell(rst) |-> (a_out == '0 && b_out == '0)); // R8
endmodule

bind dual_bus_register dbr_checker #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk(clk), .rst(rst),
  .a_in(a_in), .a_out(a_out), .a_drive(a_drive),
  .b_in(b_in), .b_out(b_out), .b_drive(b_drive),
  .ab_oe_n(ab_oe_n), .ab_pass(ab_pass), .ab_strobe(ab_strobe), .ab_hold(ab_hold),
  .ba_oe_n(ba_oe_n), .ba_pass(ba_pass), .ba_strobe(ba_strobe), .ba_hold(ba_hold)
);

// File: tb/dual_bus_register_test.sv
module dual_bus_register_test;
  localparam int W = 18;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] a_in, b_in, a_out, b_out;
  logic         a_drive, b_drive;
  logic         ab_oe_n, ab_pass, ab_strobe, ab_hold;
  logic         ba_oe_n, ba_pass, ba_strobe, ba_hold;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dual_bus_register uut (
    .clk(clk), .rst(rst),
    .a_in(a_in), .a_out(a_out), .a_drive(a_drive),
    .b_in(b_in), .b_out(b_out), .b_drive(b_drive),
    .ab_oe_n(ab_oe_n), .ab_pass(ab_pass), .ab_strobe(ab_strobe), .ab_hold(ab_hold),
    .ba_oe_n(ba_oe_n), .ba_pass(ba_pass), .ba_strobe(ba_strobe), .ba_hold(ba_hold)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic t_reset;
    rst = 1'b1; tick(3); rst = 1'b0; tick(1);
    chk("R8 b_out after reset", b_out, '0);
    chk("R8 a_out after reset", a_out, '0);
    chk("R2 b_drive off", W'(b_drive), '0);
  endtask

  task automatic t_transparent;
    ab_oe_n = 1'b0;
    a_in = 18'h2A5C3; ab_pass = 1'b1;
    tick(1); chk("R10 not yet transparent", b_out, '0);
    tick(1); chk("R1 R10 full word passes", b_out, 18'h2A5C3);
    a_in = 18'h15A3C; tick(1);
    chk("R3 follows input", b_out, 18'h15A3C);
    ab_strobe = 1'b1; ab_hold = 1'b1; tick(4);
    chk("R3 strobe ignored", b_out, 18'h15A3C);
    ab_strobe = 1'b0; ab_hold = 1'b0; tick(2);
  endtask

  task automatic t_latch_fall;
    a_in = 18'h0F0F0; tick(1);
    ab_pass = 1'b0; tick(4);
    a_in = 18'h3FFFF; tick(2);
    chk("R7 holds last tracked word", b_out, 18'h0F0F0);
  endtask

  task automatic t_clocked;
    a_in = 18'h12345; ab_strobe = 1'b1;
    tick(2); chk("R4 before capture edge", b_out, 18'h0F0F0);
    tick(1); chk("R4 captured on rise", b_out, 18'h12345);
    a_in = 18'h00001; tick(4);
    chk("R5 steady high strobe", b_out, 18'h12345);
    ab_strobe = 1'b0; tick(4);
    chk("R5 falling strobe", b_out, 18'h12345);
  endtask

  task automatic t_inhibit;
    ab_hold = 1'b1; tick(3);
    a_in = 18'h2BEEF; ab_strobe = 1'b1; tick(5);
    chk("R6 frozen rise ignored", b_out, 18'h12345);
    ab_hold = 1'b0; tick(4);
    chk("R6 unfreeze without edge", b_out, 18'h12345);
    ab_strobe = 1'b0; tick(3);
    ab_strobe = 1'b1; tick(4);
    chk("R4 capture after unfreeze", b_out, 18'h2BEEF);
  endtask

  task automatic t_isolation;
    ab_oe_n = 1'b1; ab_pass = 1'b1; tick(1);
    chk("R2 b isolated", W'(b_drive), '0);
    ab_pass = 1'b0; tick(3);
    ab_oe_n = 1'b0; tick(1);
    chk("R2 b driven", W'(b_drive), 18'h1);
    ba_oe_n = 1'b0; tick(1);
    chk("R2 a driven", W'(a_drive), 18'h1);
    ba_oe_n = 1'b1; tick(1);
    chk("R2 a isolated", W'(a_drive), '0);
  endtask

  task automatic t_independent;
    ba_oe_n = 1'b0; b_in = 18'h1C0DE; ba_pass = 1'b1; tick(3);
    chk("R9 ba transparent", a_out, 18'h1C0DE);
    chk("R9 ab untouched", b_out, 18'h2BEEF);
    ba_pass = 1'b0; tick(3);
    b_in = 18'h00F00; ba_strobe = 1'b1; tick(4);
    chk("R9 ba captured", a_out, 18'h00F00);
    chk("R9 ab still held", b_out, 18'h2BEEF);
    a_in = 18'h33333; ab_strobe = 1'b0; tick(3); ab_strobe = 1'b1; tick(4);
    chk("R9 ab captured", b_out, 18'h33333);
    chk("R9 ba unaffected", a_out, 18'h00F00);
  endtask

  task automatic t_reset_mid;
    ab_strobe = 1'b0; ba_strobe = 1'b0; tick(3);
    rst = 1'b1; tick(2); rst = 1'b0; tick(1);
    chk("R8 b cleared", b_out, '0);
    chk("R8 a cleared", a_out, '0);
    tick(5);
    chk("R8 stays cleared", b_out, '0);
  endtask

  initial begin
    rst = 1'b1; a_in = '0; b_in = '0;
    ab_oe_n = 1'b1; ab_pass = 1'b0; ab_strobe = 1'b0; ab_hold = 1'b0;
    ba_oe_n = 1'b1; ba_pass = 1'b0; ba_strobe = 1'b0; ba_hold = 1'b0;
    t_reset();
    t_transparent();
    t_latch_fall();
    t_clocked();
    t_inhibit();
    t_isolation();
    t_independent();
    t_reset_mid();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      vectors++; miscompares++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule